// File: doc/BRIEF.md
# Six-Face Routing Switch Block

This block is the routing crossing point of a stacked, three-dimensional programmable-logic fabric. It has six faces, and each face carries `W` routing terminals. Every terminal owns exactly one programmable switch to each of the other five faces. The block therefore holds 15·W switches, the fewest that still let any set of connection requests pass as long as each face carries at most `W` nets.

The switch pattern is fixed and symmetric. Track `t` on one face always meets track `W-1-t` on every other face. Tracks `t` and `W-1-t` together form an independent two-track sub-block of 30 switches. Inside a sub-block, the two partners that a terminal reaches on two different faces never share a switch with each other. When `W` is odd, the middle track maps to itself, and its six terminals form a 15-switch clique.

Configuration arrives on a serial chain with one bit per switch. A small controller has three states: `CFG_IDLE` (no configuration yet), `CFG_LOAD` (shifting) and `CFG_RUN` (routing live). It moves `CFG_IDLE→CFG_LOAD` and `CFG_RUN→CFG_LOAD` while `cfg_en` is high. It moves `CFG_LOAD→CFG_RUN` on the first clock edge with `cfg_en` low, and it holds its state otherwise. Bidirectional routing wires are modelled as separate input and output buses. A per-terminal conflict flag marks a terminal that two enabled sources drive at once.

Top module: `sb3d_switch_block`

## Requirements
- R1: After reset the controller is in `CFG_IDLE`, all configuration bits are 0, and `term_out` and `term_conflict` are all 0.
- R2: Outside `CFG_RUN` (after reset, and from the edge that samples `cfg_en` high until the edge that samples it low), `term_out` and `term_conflict` are all 0 whatever `term_in` is.
- R3: Each clock edge with `cfg_en` high shifts `cfg_bit` into configuration bit 0 and moves every bit up by one, so a vector of 15·W bits sent MSB-first lands in its own positions. Configuration bits hold their values while `cfg_en` is low.
- R4: Terminal index is `face*W + track`, with faces 0..5 numbered front, rear, left, right, top, bottom. The switch between faces a<b joins track t on face a to track W-1-t on face b. No other pairs of terminals are joined.
- R5: Switch numbering: the pair slot of faces a<b is a*(11-a)/2 + (b-a-1), giving 0..14. For track t on the lower face, let m = W-1-t and blk = min(t,m). The bit index is blk*30 + slot when t = m, and blk*30 + 2*slot + (t>m ? 1 : 0) otherwise.
- R6: In `CFG_RUN`, each `term_out` bit is the OR of `term_in` over those of its five partners whose switch bit is 1.
- R7: A switch whose bit is 0 has no effect: raising the input of that partner alone leaves the terminal's output at 0.
- R8: In `CFG_RUN`, `term_conflict` of a terminal is 1 exactly when two or more enabled partners have their input at 1.
- R9: When `cfg_en` is raised again in `CFG_RUN`, the outputs go quiet, and the newly loaded vector replaces the old one from the first edge with `cfg_en` low.
- R10: For odd W, the middle track of all six faces forms a full clique: each middle terminal reaches the middle terminal of every other face.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| term_in | input | 6*W | Incoming value of each terminal, index face*W+track |
| term_out | output | 6*W | Value driven onto each terminal through enabled switches |
| term_conflict | output | 6*W | Terminal is driven by two or more enabled, active partners |

## Verification
A configuration bit that lands in the wrong position shows up as a wrong or missing connection. The block reports this on the first input pattern applied after loading, because outputs follow inputs with no register in between. The sweep loads every single-switch configuration and drives every terminal alone, so a wrong topology or bit index is seen at once. A controller stuck outside `CFG_RUN` is seen in the same way: every output stays at zero. A wrong conflict count shows on the first pair of active partners. The all-ones configuration with every pair of inputs driven covers this case.

// File: rtl/sb3d_pkg.sv
package sb3d_pkg;

    typedef enum logic [1:0] {
        CFG_IDLE = 2'd0,
        CFG_LOAD = 2'd1,
        CFG_RUN  = 2'd2
    } cfg_state_e;

    localparam int FACES      = 6;
    localparam int PEERS      = FACES - 1;
    localparam int PAIRS      = FACES * PEERS / 2;
    localparam int BLK_BITS   = 2 * PAIRS;

    // slot of the unordered face pair lo<hi, 0..14
    function automatic int pair_slot(input int lo, input int hi);
        return lo * (2 * FACES - 1 - lo) / 2 + (hi - lo - 1);
    endfunction

    // chain position of the switch at track trk of the lower face of a pair
    function automatic int switch_bit(input int w, input int slot, input int trk);
        int mir;
        int blk;
        mir = w - 1 - trk;
        blk = (trk < mir) ? trk : mir;
        if (trk == mir)
            return blk * BLK_BITS + slot;
        return blk * BLK_BITS + 2 * slot + ((trk > mir) ? 1 : 0);
    endfunction

endpackage

// File: rtl/sb3d_cfg_chain.sv
module sb3d_cfg_chain #(
    parameter int NBITS = 45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [NBITS-1:0] cfg_q,
    output logic             run
);
    import sb3d_pkg::*;

    cfg_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CFG_IDLE: if (cfg_en)  state_nx = CFG_LOAD;
            CFG_LOAD: if (!cfg_en) state_nx = CFG_RUN;
            CFG_RUN:  if (cfg_en)  state_nx = CFG_LOAD;
            default:               state_nx = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CFG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        run = (state == CFG_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_en) cfg_q <= {cfg_q[NBITS-2:0], cfg_bit};
    end

    AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (state == CFG_LOAD)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q)); // R3
    AST_RUN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_LOAD && !cfg_en) |=> run); // R9

endmodule

// File: rtl/sb3d_terminal.sv
module sb3d_terminal #(
    parameter int NP = 5
) (
    input  logic          run,
    input  logic [NP-1:0] peer_in,
    input  logic [NP-1:0] peer_en,
    output logic          drive,
    output logic          conflict
);
    localparam int CW = $clog2(NP + 1);

    logic [NP-1:0] active;
    logic [CW-1:0] n_active;

    always_comb begin
        active   = peer_in & peer_en;
        n_active = '0;
        for (int i = 0; i < NP; i++)
            n_active = n_active + CW'(active[i]);
        drive    = run && (|active);
        conflict = run && (n_active >= CW'(2));
    end

endmodule

// File: rtl/sb3d_switch_block.sv
module sb3d_switch_block #(
    parameter int W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [6*W-1:0]   term_in,
    output logic [6*W-1:0]   term_out,
    output logic [6*W-1:0]   term_conflict
);
    import sb3d_pkg::*;

    localparam int NSW  = PAIRS * W;
    localparam int NTRM = FACES * W;

    logic [NSW-1:0] cfg_q;
    logic           run;

    sb3d_cfg_chain #(.NBITS(NSW)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .cfg_q   (cfg_q),
        .run     (run)
    );

    for (genvar f = 0; f < FACES; f++) begin : g_face
        for (genvar t = 0; t < W; t++) begin : g_trk
            logic [PEERS-1:0] p_in;
            logic [PEERS-1:0] p_en;
            for (genvar g = 0; g < FACES; g++) begin : g_peer
                if (g != f) begin : g_link
                    localparam int Q   = (g < f) ? g : g - 1;
                    localparam int LOF = (f < g) ? f : g;
                    localparam int HIF = (f < g) ? g : f;
                    localparam int LOT = (f < g) ? t : W - 1 - t;
                    localparam int SB  = switch_bit(W, pair_slot(LOF, HIF), LOT);
                    assign p_in[Q] = term_in[g*W + (W-1-t)];
                    assign p_en[Q] = cfg_q[SB];
                end
            end
            sb3d_terminal #(.NP(PEERS)) u_term (
                .run      (run),
                .peer_in  (p_in),
                .peer_en  (p_en),
                .drive    (term_out[f*W + t]),
                .conflict (term_conflict[f*W + t])
            );
        end
    end

    AST_SILENT_UNLESS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (term_out == '0 && term_conflict == '0)); // R2
    AST_CONFLICT_HAS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (term_conflict & ~term_out) == '0); // R8
    AST_NO_CFG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |-> (term_out == '0)); // R7
    AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (term_in == '0) |-> (term_out == '0)); // R6

    localparam int UNUSED_NTRM = NTRM;

endmodule

// File: tb/test_sb3d_switch_block.sv
module test_sb3d_switch_block;
    localparam int W    = 3;
    localparam int NSW  = 15 * W;
    localparam int NT   = 6 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_bit = 1'b0;
    logic [NT-1:0] term_in = '0;
    logic [NT-1:0] term_out;
    logic [NT-1:0] term_conflict;

    int n_checks = 0;
    int n_fail   = 0;
    int sw_a [NSW];
    int sw_b [NSW];

    always #5 clk = ~clk;

    sb3d_switch_block #(.W(W)) i_sb3d_switch_block (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .term_in(term_in), .term_out(term_out), .term_conflict(term_conflict)
    );

    task automatic check(input string req, input logic [NT-1:0] act,
                         input logic [NT-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // enumerate the chain: sub-block by sub-block, face pair by face pair
    task automatic build_map();
        int k;
        int slot;
        k = 0;
        for (int b = 0; b < (W + 1) / 2; b++) begin
            slot = 0;
            for (int a = 0; a < 6; a++)
                for (int c = a + 1; c < 6; c++) begin
                    if (b == W - 1 - b) begin
                        sw_a[k] = a*W + b; sw_b[k] = c*W + b; k++;
                    end else begin
                        sw_a[k]   = a*W + b;         sw_b[k]   = c*W + (W-1-b); // t<m
                        sw_a[k+1] = a*W + (W-1-b);   sw_b[k+1] = c*W + b;       // t>m
                        k += 2;
                    end
                    slot++;
                end
        end
    endtask

    task automatic model(input logic [NSW-1:0] cfg, input logic [NT-1:0] ins,
                         output logic [NT-1:0] o, output logic [NT-1:0] cf);
        int cnt [NT];
        for (int i = 0; i < NT; i++) cnt[i] = 0;
        for (int k = 0; k < NSW; k++)
            if (cfg[k]) begin
                if (ins[sw_b[k]]) cnt[sw_a[k]]++;
                if (ins[sw_a[k]]) cnt[sw_b[k]]++;
            end
        for (int i = 0; i < NT; i++) begin
            o[i]  = (cnt[i] >= 1);
            cf[i] = (cnt[i] >= 2);
        end
    endtask

    task automatic load(input logic [NSW-1:0] v);
        for (int i = NSW - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = v[i];
            if (i == NSW / 2) begin
                term_in = '1;
                #1 check("R2 outputs quiet while loading", term_out | term_conflict, '0);
            end
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        term_in = '0;
        @(negedge clk);
    endtask

    task automatic apply(input string req, input logic [NSW-1:0] cfg,
                         input logic [NT-1:0] ins);
        logic [NT-1:0] eo;
        logic [NT-1:0] ec;
        term_in = ins;
        #2;
        model(cfg, ins, eo, ec);
        check(req, term_out, eo);
        check(req, term_conflict, ec);
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [NSW-1:0] cfg;
        build_map();
        #22 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", term_out | term_conflict, '0);
        term_in = '1;
        #1 check("R1 R2 idle ignores inputs", term_out | term_conflict, '0);
        term_in = '0;

        // R4 R5 R7: every single switch, every lone driver
        for (int k = 0; k < NSW; k++) begin
            cfg = '0;
            cfg[k] = 1'b1;
            load(cfg);
            for (int d = 0; d < NT; d++)
                apply("R4 R5 R7 one switch one driver", cfg, NT'(1) << d);
        end

        // R8: all switches on, every pair of drivers
        cfg = '1;
        load(cfg);
        for (int a = 0; a < NT; a++)
            for (int b = a + 1; b < NT; b++)
                apply("R8 conflict pairs", cfg, (NT'(1) << a) | (NT'(1) << b));

        // R10: middle clique, each middle terminal reaches the other five
        for (int f = 0; f < 6; f++) begin
            logic [NT-1:0] exp;
            exp = '0;
            for (int g = 0; g < 6; g++)
                if (g != f) exp[g*W + W/2] = 1'b1;
            term_in = NT'(1) << (f*W + W/2);
            #2 check("R10 middle clique", term_out, exp);
        end

        // R6 R9: random reloads and input patterns
        for (int r = 0; r < 20; r++) begin
            cfg = {$urandom, $urandom};
            load(cfg);
            for (int p = 0; p < 30; p++)
                apply("R6 R9 random config", cfg, NT'($urandom));
        end

        // R3: bits hold while cfg_en low across many edges
        repeat (20) @(negedge clk);
        apply("R3 configuration holds", cfg, '1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule